// File: doc/BRIEF.md
# Windowed-Disable Watchdog Timer

This block supervises software with a 16-bit up-counter. Unless software services it in time, the counter runs past its top value and the block raises a one-cycle internal reset pulse. It also holds an active-low reset output low for a fixed number of clocks, so that other parts of the system can be reset too. The counter advances on the system clock divided by 2 or by 128. A service strobe loads the counter's upper byte from an 8-bit reload input and clears the lower byte. Software therefore sets the supervised interval by choosing the reload value and the divider.

The watchdog is armed whenever it leaves reset. Early boot code may switch it off, but only until an end-of-initialization strobe arrives. After that strobe the switch-off request is ignored until the next reset. A watchdog overflow counts as a reset: the block comes back with its reset defaults.

Top module: `wdt_windowed`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `rst_out_n` is 1 and `wd_rst_o` is 0.
- R2: A service (`svc_i` high at a clock edge) loads the counter with `{reload_i, 8'h00}` and clears the prescaler. It latches `div_sel_i` (0 selects divide by FAST_DIV=2, 1 selects divide by SLOW_DIV=128). The next overflow comes (2^16 - reload*256) * divider clocks after the service edge.
- R3: After `rst_n` rises, the defaults are divider 2 and count 0. The first overflow therefore comes 2^17 clocks after reset release.
- R4: An overflow raises `wd_rst_o` for exactly one cycle and drives `rst_out_n` low for exactly HOLD_CYCLES=16 cycles, starting in the same cycle.
- R5: Before the end-of-initialization strobe, a `dis_i` pulse stops the counter. While it is stopped, no overflow occurs.
- R6: Once `init_done_i` has been seen, `dis_i` has no effect until the next reset, and overflows occur as in R2.
- R7: When `rst_out_n` releases after an overflow, the block is back at its reset defaults. The next overflow follows 2^17 clocks later, and disabling is allowed again.
- R8: Changes on `reload_i` or `div_sel_i` between services do not alter the interval that is running.
- R9: A service in the middle of an interval restarts a complete interval, measured from that service.
- R10: When a service falls on the same edge as an overflow, the service wins and no reset is produced.
- R11: When `dis_i` and `init_done_i` are high on the same edge, the disable takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| svc_i | input | 1 | Service strobe |
| dis_i | input | 1 | Disable request |
| init_done_i | input | 1 | End-of-initialization strobe |
| div_sel_i | input | 1 | Divider select, applied at service: 0 = /2, 1 = /128 |
| reload_i | input | 8 | Upper-byte reload value |
| wd_rst_o | output | 1 | One-cycle internal reset pulse on overflow |
| rst_out_n | output | 1 | Active-low reset output, held low after overflow |

## Verification
The hardest case to reach is a service that lands on exactly the edge where the counter would overflow. The bench first measures an interval arithmetically from the reload value and the divider. It then starts a second interval and raises `svc_i` one cycle before the computed overflow edge, so that the two events coincide. To keep exhaustive sweeps short, the bench uses a reduced configuration: an 8-bit counter, a slow divider of 8 and a hold of 4. With it the bench sweeps every reload value under both dividers.

// File: rtl/wdt_windowed.sv
module wdt_windowed #(
  parameter int CNT_W       = 16,
  parameter int FAST_DIV    = 2,
  parameter int SLOW_DIV    = 128,
  parameter int HOLD_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               svc_i,
  input  logic               dis_i,
  input  logic               init_done_i,
  input  logic               div_sel_i,
  input  logic [CNT_W/2-1:0] reload_i,
  output logic               wd_rst_o,
  output logic               rst_out_n
);
  localparam int RL_W   = CNT_W / 2;
  localparam int PRE_W  = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);

  logic [CNT_W-1:0]  cnt;
  logic [PRE_W-1:0]  pre;
  logic [HOLD_W-1:0] hold;
  logic              en, init_seen, slow_q;

  wire              holding  = (hold != '0);
  wire [PRE_W-1:0]  pre_last = slow_q ? PRE_W'(SLOW_DIV - 1) : PRE_W'(FAST_DIV - 1);
  wire              tick     = en && (pre == pre_last);
  wire              fire     = tick && (&cnt) && !svc_i;

  assign rst_out_n = !holding;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      pre       <= '0;
      hold      <= '0;
      en        <= 1'b1;
      init_seen <= 1'b0;
      slow_q    <= 1'b0;
      wd_rst_o  <= 1'b0;
    end else if (holding) begin
      hold      <= hold - 1'b1;
      cnt       <= '0;
      pre       <= '0;
      en        <= 1'b1;
      init_seen <= 1'b0;
      slow_q    <= 1'b0;
      wd_rst_o  <= 1'b0;
    end else begin
      wd_rst_o <= fire;
      if (fire) begin
        hold      <= HOLD_W'(HOLD_CYCLES);
        cnt       <= '0;
        pre       <= '0;
        en        <= 1'b1;
        init_seen <= 1'b0;
        slow_q    <= 1'b0;
      end else begin
        if (init_done_i) init_seen <= 1'b1;
        if (dis_i && !init_seen) en <= 1'b0;
        if (svc_i) begin
          cnt    <= {reload_i, {(CNT_W - RL_W){1'b0}}};
          pre    <= '0;
          slow_q <= div_sel_i;
        end else if (en) begin
          pre <= tick ? '0 : pre + 1'b1;
          if (tick) cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assert_pulse_with_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_o |-> !rst_out_n);
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst_o |=> !wd_rst_o);
  assert_held_defaults_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_out_n |-> (cnt == '0 && en && !init_seen));
  assert_stopped_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!en && !wd_rst_o));
  assert_late_disable_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (init_seen && en) |=> en);
  assert_service_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_i && rst_out_n) |=> (cnt == {$past(reload_i), {(CNT_W - RL_W){1'b0}}} && !wd_rst_o));
endmodule

// File: tb/wdt_windowed_bench.sv
module wdt_windowed_bench;
  localparam int W = 8, H = 4, FD = 2, SD = 8, HOLD = 4;
  localparam int DEF_T = (1 << W) * FD;

  logic clk = 0, rst_n = 0, svc = 0, dis = 0, idone = 0, dsel = 0;
  logic [H-1:0] rl = '0;
  logic wd_rst, rout_n;
  int cyc = 0, checks = 0, fails = 0;

  wdt_windowed #(.CNT_W(W), .FAST_DIV(FD), .SLOW_DIV(SD), .HOLD_CYCLES(HOLD)) u_wdt_windowed (
    .clk(clk), .rst_n(rst_n), .svc_i(svc), .dis_i(dis), .init_done_i(idone),
    .div_sel_i(dsel), .reload_i(rl), .wd_rst_o(wd_rst), .rst_out_n(rout_n));

  always #4 clk = ~clk;
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; svc = 0; dis = 0; idone = 0; dsel = 0; rl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic service(input int r, input bit s, output int at);
    @(negedge clk);
    svc = 1; rl = H'(r); dsel = s;
    @(negedge clk);
    svc = 0;
    at = cyc;
  endtask

  task automatic wait_fire(input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (wd_rst) begin at = cyc; break; end
    end
  endtask

  task automatic measure_hold(output int rel);
    int n = 0;
    while (!rout_n && n < 100) begin
      n++;
      @(negedge clk);
      if (n == 1) check(!wd_rst, "R4 pulse width", wd_rst, 0);
    end
    check(n == HOLD, "R4 reset output low length", n, HOLD);
    rel = cyc;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog timeout");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int s, f, rel, t;
    rst_n = 0;
    repeat (2) @(negedge clk);
    check(rout_n && !wd_rst, "R1 during reset", {rout_n, wd_rst}, 2);
    rst_n = 1;
    @(negedge clk);
    check(rout_n && !wd_rst, "R1 after release", {rout_n, wd_rst}, 2);

    do_reset();
    wait_fire(DEF_T + 50, f);
    check(f == DEF_T, "R3 default interval", f, DEF_T);
    measure_hold(rel);
    wait_fire(DEF_T + 50, f);
    check(f - rel == DEF_T, "R7 interval after overflow restart", f - rel, DEF_T);
    measure_hold(rel);

    for (int sel = 0; sel < 2; sel++)
      for (int r = 0; r < (1 << H); r++) begin
        service(r, sel[0], s);
        t = ((1 << W) - (r << H)) * (sel ? SD : FD);
        wait_fire(t + 50, f);
        check(f - s == t, $sformatf("R2 sweep sel=%0d r=%0d", sel, r), f - s, t);
        measure_hold(rel);
      end

    service(3, 0, s);
    @(negedge clk); rl = 4'd9; dsel = 1;
    t = ((1 << W) - (3 << H)) * FD;
    wait_fire(t + 50, f);
    check(f - s == t, "R8 mid-interval config change ignored", f - s, t);
    measure_hold(rel);

    service(10, 1, s);
    repeat (37) @(negedge clk);
    service(10, 1, s);
    t = ((1 << W) - (10 << H)) * SD;
    wait_fire(t + 50, f);
    check(f - s == t, "R9 re-service restarts interval", f - s, t);
    measure_hold(rel);

    service(12, 0, s);
    t = ((1 << W) - (12 << H)) * FD;
    while (cyc < s + t - 1) @(negedge clk);
    svc = 1;
    @(negedge clk);
    svc = 0;
    check(!wd_rst && rout_n && cyc == s + t, "R10 service wins over overflow",
          {wd_rst, rout_n}, 1);
    s = cyc;
    wait_fire(t + 50, f);
    check(f - s == t, "R10 interval after colliding service", f - s, t);
    measure_hold(rel);

    do_reset();
    service(0, 0, s);
    repeat (5) @(negedge clk);
    dis = 1; @(negedge clk); dis = 0;
    wait_fire(DEF_T + 200, f);
    check(f == -1 && rout_n, "R5 early disable stops watchdog", f, -1);

    do_reset();
    dis = 1; idone = 1; @(negedge clk); dis = 0; idone = 0;
    wait_fire(DEF_T + 200, f);
    check(f == -1, "R11 disable with simultaneous init strobe", f, -1);

    do_reset();
    idone = 1; @(negedge clk); idone = 0;
    dis = 1; @(negedge clk); dis = 0;
    service(8, 0, s);
    t = ((1 << W) - (8 << H)) * FD;
    wait_fire(t + 50, f);
    check(f - s == t, "R6 late disable ignored", f - s, t);
    measure_hold(rel);

    dis = 1; @(negedge clk); dis = 0;
    wait_fire(DEF_T + 200, f);
    check(f == -1, "R7 disable allowed again after overflow", f, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule